// File: doc/BRIEF.md
# Two-Level Grouped Carry Lookahead Adder

This block is a purely combinational adder that is `N = L * M` bits wide. It sums two operands and a single carry input, and it returns the sum together with a carry output. The operand width is split into `M` groups, each `L` bits wide.

Each group does two jobs:
- It adds its own slice of the operands with an inner adder.
- It reduces its bit-level propagate and generate terms to one group propagate and one group generate. Neither of these depends on the carry that enters the group.

A carry network at the top level takes the group terms and the external carry input. From them it produces the carry into every group and the final carry output.

Two compile-time parameters choose the structure, and they are independent of each other:
- **Inner adder:** a plain rippling chain or a flat lookahead sum-of-products.
- **Group carry network:** rippling or flat lookahead.

Every combination of the two gives the same arithmetic result. The combinations differ only in logic depth and area. Integrators choose the combination that suits their timing budget. They instantiate the block wherever a registered datapath needs a single-cycle add.

Top module: `grp_cla_adder`

## Requirements
- R1: For every parameter combination, `{co, sum}` equals `op_a + op_b + ci`, computed as an `N+1`-bit unsigned value.
- R2: Each bit position forms generate as `a AND b` and propagate as `a OR b` (inclusive OR). Whenever generate is 1, propagate is also 1.
- R3: A group's propagate is the AND of its `L` bit propagates. A group's generate is the lookahead OR-of-products of its bits, with the group carry-in forced to 0. As a result, a group whose bits all propagate passes an incoming carry on to the next group.
- R4: Parameter `INNER_STYLE` (`CS_RIPPLE` = 0, `CS_LOOKAHEAD` = 1) selects the inner adder type. It has no effect on the result.
- R5: Parameter `GROUP_STYLE` (`CS_RIPPLE` = 0, `CS_LOOKAHEAD` = 1) selects the group carry network type. It has no effect on the result.
- R6: The external carry input is the carry into group 0. With both operands zero and `ci` = 1, the sum is 1 and `co` is 0.
- R7: `co` equals the generate of the last group, OR'd with the AND of the last group's propagate and the carry into the last group. All-ones plus `ci` = 1 gives a sum of 0 and `co` = 1. All-ones plus zero with `ci` = 0 gives `co` = 0.
- R8: A group in which some bit has `a` = `b` = 1 may raise its propagate and its generate together. In that case the carries are still correct; for example, all-ones plus all-ones with `ci` = 0 gives `co` = 1 and `sum` = all-ones minus 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| co | output | 1 | Carry out of bit N-1 |

## Verification
The hardest case to reach from the ports is a long carry that travels across group boundaries. This requires every group between its source and its destination to show propagate without generate. Random operands almost never line up that way.

The stimulus builds such chains on purpose:
- It uses one operand equal to all-ones with the other zero and the carry input set, so the carry passes through every group.
- It generates a carry in a single group and makes all the groups above it propagate only.
- It adds all-ones to all-ones, so every group raises propagate and generate together.

Each pattern is applied at the same time to instances covering all four structural combinations, plus one instance with an odd group geometry.

// File: rtl/grp_cla_pkg.sv
package grp_cla_pkg;
    // Selects how a chain of carries is computed
    typedef enum logic {
        CS_RIPPLE    = 1'b0,
        CS_LOOKAHEAD = 1'b1
    } carry_style_e;
endpackage

// File: rtl/grp_cla_bitcell.sv
// grp_cla_bitcell: one-bit cell. Forms generate (AND), inclusive-OR
// propagate and the sum bit. It has no carry output, and its p/g
// do not depend on the incoming carry.
module grp_cla_bitcell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic p_o,
    output logic g_o,
    output logic s_o
);
    // Purpose: bit-level propagate, generate and sum
    always_comb begin
        g_o = a_i & b_i;
        p_o = a_i | b_i;
        s_o = a_i ^ b_i ^ c_i;
    end

    // Purpose: generate must never appear without propagate
    always_comb begin
        AST_GEN_IMPLIES_PROP: assert (!g_o || p_o) else $error("gen without prop"); // R2
    end
endmodule

// File: rtl/grp_cla_group.sv
// grp_cla_group: L-bit group. Holds the inner adder (ripple or flat
// lookahead, chosen by INNER_STYLE) and forms the group propagate and
// generate, which ignore the group carry-in.
// Assumes L >= 1.
module grp_cla_group
    import grp_cla_pkg::*;
#(
    parameter int           L           = 8,
    parameter carry_style_e INNER_STYLE = CS_LOOKAHEAD
) (
    input  logic [L-1:0] a_i,
    input  logic [L-1:0] b_i,
    input  logic         cin_i,
    output logic [L-1:0] s_o,
    output logic         gp_o,
    output logic         gg_o
);
    logic [L-1:0] bp;
    logic [L-1:0] bg;
    logic [L:0]   cc;

    // Purpose: one cell per bit position
    for (genvar i = 0; i < L; i++) begin : g_cell
        grp_cla_bitcell u_cell (
            .a_i (a_i[i]),
            .b_i (b_i[i]),
            .c_i (cc[i]),
            .p_o (bp[i]),
            .g_o (bg[i]),
            .s_o (s_o[i])
        );
    end

    if (INNER_STYLE == CS_RIPPLE) begin : g_ripple
        // Purpose: carry passes one bit at a time
        always_comb begin
            logic run;
            run   = cin_i;
            cc[0] = cin_i;
            for (int i = 0; i < L; i++) begin
                run     = bg[i] | (bp[i] & run);
                cc[i+1] = run;
            end
        end
    end else begin : g_lookahead
        // Purpose: each carry as a flat OR of products, cin acts as g[-1]
        always_comb begin
            logic term;
            logic acc;
            cc[0] = cin_i;
            for (int i = 1; i <= L; i++) begin
                acc = 1'b0;
                for (int j = -1; j < i; j++) begin
                    term = (j < 0) ? cin_i : bg[j];
                    for (int k = j + 1; k < i; k++) begin
                        term = term & bp[k];
                    end
                    acc = acc | term;
                end
                cc[i] = acc;
            end
        end
    end

    // Purpose: group propagate and generate, independent of cin
    always_comb begin
        logic term;
        gp_o = &bp;
        gg_o = 1'b0;
        for (int j = 0; j < L; j++) begin
            term = bg[j];
            for (int k = j + 1; k < L; k++) begin
                term = term & bp[k];
            end
            gg_o = gg_o | term;
        end
    end

    // Purpose: inner adder carry out agrees with group P/G
    always_comb begin
        AST_GROUP_PG_CARRY: assert (cc[L] == (gg_o | (gp_o & cin_i)))
            else $error("group P/G disagree with inner carry"); // R3
    end
endmodule

// File: rtl/grp_cla_carry_net.sv
// grp_cla_carry_net: top-level carry network over M groups. Produces
// the carry into each group and the carry-out; GROUP_STYLE picks a
// ripple or flat lookahead form. External carry-in is index -1.
module grp_cla_carry_net
    import grp_cla_pkg::*;
#(
    parameter int           M           = 4,
    parameter carry_style_e GROUP_STYLE = CS_LOOKAHEAD
) (
    input  logic [M-1:0] gp_i,
    input  logic [M-1:0] gg_i,
    input  logic         cin_i,
    output logic [M:0]   c_o
);
    if (GROUP_STYLE == CS_RIPPLE) begin : g_ripple
        // Purpose: group carries chained one after another
        always_comb begin
            logic run;
            run    = cin_i;
            c_o[0] = cin_i;
            for (int i = 0; i < M; i++) begin
                run      = gg_i[i] | (gp_i[i] & run);
                c_o[i+1] = run;
            end
        end
    end else begin : g_lookahead
        // Purpose: each group carry as flat OR of products
        always_comb begin
            logic term;
            logic acc;
            c_o[0] = cin_i;
            for (int i = 1; i <= M; i++) begin
                acc = 1'b0;
                for (int j = -1; j < i; j++) begin
                    term = (j < 0) ? cin_i : gg_i[j];
                    for (int k = j + 1; k < i; k++) begin
                        term = term & gp_i[k];
                    end
                    acc = acc | term;
                end
                c_o[i] = acc;
            end
        end
    end

    // Purpose: a generating group always sends a carry; a killing group never does
    always_comb begin
        for (int i = 0; i < M; i++) begin
            AST_GEN_FORCES_CARRY: assert (!gg_i[i] || c_o[i+1])
                else $error("generate lost"); // R8
            AST_KILL_BLOCKS_CARRY: assert (gg_i[i] || gp_i[i] || !c_o[i+1])
                else $error("carry through killing group"); // R7
        end
    end
endmodule

// File: rtl/grp_cla_adder.sv
// grp_cla_adder: N = L*M bit combinational adder built from M groups
// of L bits and a group carry network. Inner adder and group network
// style are set independently by parameter.
module grp_cla_adder
    import grp_cla_pkg::*;
#(
    parameter int           L           = 8,
    parameter int           M           = 4,
    parameter carry_style_e INNER_STYLE = CS_LOOKAHEAD,
    parameter carry_style_e GROUP_STYLE = CS_LOOKAHEAD,
    localparam int          N           = L * M
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         ci,
    output logic [N-1:0] sum,
    output logic         co
);
    logic [M-1:0] grp_p;
    logic [M-1:0] grp_g;
    logic [M:0]   grp_c;

    // Purpose: one group block per L-bit slice
    for (genvar i = 0; i < M; i++) begin : g_grp
        grp_cla_group #(
            .L           (L),
            .INNER_STYLE (INNER_STYLE)
        ) u_grp (
            .a_i   (op_a[i*L +: L]),
            .b_i   (op_b[i*L +: L]),
            .cin_i (grp_c[i]),
            .s_o   (sum[i*L +: L]),
            .gp_o  (grp_p[i]),
            .gg_o  (grp_g[i])
        );
    end

    grp_cla_carry_net #(
        .M           (M),
        .GROUP_STYLE (GROUP_STYLE)
    ) u_net (
        .gp_i  (grp_p),
        .gg_i  (grp_g),
        .cin_i (ci),
        .c_o   (grp_c)
    );

    // Purpose: carry-out is the carry beyond the last group
    always_comb co = grp_c[M];

    // Purpose: end-to-end arithmetic and carry-in handling
    always_comb begin
        AST_SUM_MATCHES: assert ({co, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, ci}))
            else $error("sum mismatch"); // R1
        AST_CIN_ONLY: assert (!((op_a == '0) && (op_b == '0)) || ((sum == {{(N-1){1'b0}}, ci}) && !co))
            else $error("carry-in not into group 0"); // R6
    end
endmodule

// File: tb/test_grp_cla_adder.sv
module test_grp_cla_adder;
    import grp_cla_pkg::*;

    localparam int W = 32;
    localparam int WS = 15;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [W-1:0]  a, b;
    logic          cin;
    logic [W-1:0]  s_ll, s_rr, s_rl, s_lr;
    logic          c_ll, c_rr, c_rl, c_lr;
    logic [WS-1:0] s_sm;
    logic          c_sm;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // lookahead inner, lookahead group (default)
    grp_cla_adder i_grp_cla_adder (
        .op_a(a), .op_b(b), .ci(cin), .sum(s_ll), .co(c_ll));
    grp_cla_adder #(.L(8), .M(4), .INNER_STYLE(CS_RIPPLE), .GROUP_STYLE(CS_RIPPLE)) i_grp_cla_adder_rr (
        .op_a(a), .op_b(b), .ci(cin), .sum(s_rr), .co(c_rr));
    grp_cla_adder #(.L(8), .M(4), .INNER_STYLE(CS_RIPPLE), .GROUP_STYLE(CS_LOOKAHEAD)) i_grp_cla_adder_rl (
        .op_a(a), .op_b(b), .ci(cin), .sum(s_rl), .co(c_rl));
    grp_cla_adder #(.L(8), .M(4), .INNER_STYLE(CS_LOOKAHEAD), .GROUP_STYLE(CS_RIPPLE)) i_grp_cla_adder_lr (
        .op_a(a), .op_b(b), .ci(cin), .sum(s_lr), .co(c_lr));
    grp_cla_adder #(.L(5), .M(3), .INNER_STYLE(CS_LOOKAHEAD), .GROUP_STYLE(CS_RIPPLE)) i_grp_cla_adder_sm (
        .op_a(a[WS-1:0]), .op_b(b[WS-1:0]), .ci(cin), .sum(s_sm), .co(c_sm));

    task automatic cmp(input string tag, input string inst, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, inst, act, exp);
        end
    endtask

    // Drive on falling edge, compare after the rising edge against integer model
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc, input string tag);
        longint unsigned full, fsm;
        @(negedge clk);
        a = va; b = vb; cin = vc;
        full = longint'(va) + longint'(vb) + longint'(vc);
        fsm  = longint'(va[WS-1:0]) + longint'(vb[WS-1:0]) + longint'(vc);
        @(posedge clk);
        #1;
        cmp(tag, "LL R4/R5", {c_ll, s_ll}, full[W:0]);
        cmp(tag, "RR R4/R5", {c_rr, s_rr}, full[W:0]);
        cmp(tag, "RL R4/R5", {c_rl, s_rl}, full[W:0]);
        cmp(tag, "LR R4/R5", {c_lr, s_lr}, full[W:0]);
        cmp(tag, "small R1", {{(W-WS){1'b0}}, c_sm, s_sm}, {{(W-WS){1'b0}}, fsm[WS:0]});
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        repeat (2) @(posedge clk);
        apply('0, '0, 1'b0, "R1 zero");
        apply('0, '0, 1'b1, "R6 cin only");
        apply('1, '0, 1'b1, "R7 all-ones plus cin");
        apply('1, '0, 1'b0, "R7 all-ones no carry");
        apply('1, '1, 1'b0, "R8 both all-ones");
        apply('1, '1, 1'b1, "R8 both all-ones cin");
        apply(32'h0000_00FF, 32'h0000_0000, 1'b1, "R3 group0 propagate");
        apply(32'h0000_0080, 32'h0000_0080, 1'b0, "R3 gen into group1");
        apply(32'hFFFF_FF80, 32'h0000_0080, 1'b0, "R3 gen across groups");
        apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R7 top gen");
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R3 propagate only");
        apply(32'h0101_0101, 32'h0101_0101, 1'b0, "R2 bit gen");
        apply(32'h0000_7FFF, 32'h0000_0001, 1'b0, "R1 small carry chain");
        for (int i = 0; i < 400; i++) begin
            apply($urandom, $urandom, 1'($urandom), "R1 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1: got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule